// File: doc/BRIEF.md
# Block-Mode Word DMA Channel

This block is a single DMA channel that copies 32-bit words between a word-addressed system memory and one peripheral data port. Software sets up a byte address register and a block register. The number of words to move is the upper half of the block register times its lower half. Software then writes the control register. A write to the control register with bit 24 set starts the channel. The full 32-bit control value decides the direction. Any value that is neither of the two direction codes finishes at once and moves nothing.

While the channel runs, the address register steps by four bytes after each word. At the end it holds the start address plus the number of bytes moved. The channel clears control bit 24, which is also the `busy` output, and gives a one-cycle `irq` pulse. The memory port uses one request per word. A read returns its data on the cycle after the request. The peripheral side uses a valid/ready handshake in each direction.

The controller is a state machine with seven states:
- `ST_IDLE` waits for a start.
- `ST_SETUP` decodes the control value and the length.
- `ST_MEM_RD` issues a memory read.
- `ST_MEM_LAT` captures the read data.
- `ST_PUSH` offers the word to the peripheral.
- `ST_PULL` accepts a word from the peripheral and writes it to memory in the same cycle.
- `ST_FINISH` raises the interrupt and clears bit 24.

The transitions are:
- IDLE→SETUP on a start write.
- SETUP→FINISH for an unknown code or zero length.
- SETUP→MEM_RD for memory-to-peripheral.
- SETUP→PULL for peripheral-to-memory.
- MEM_RD→MEM_LAT→PUSH always.
- PUSH→MEM_RD on a non-final accepted word.
- PUSH→FINISH on the final accepted word.
- PULL→PULL on a non-final accepted word.
- PULL→FINISH on the final accepted word.
- FINISH→IDLE always.

Top module: `blkdma_channel`

## Requirements
- R1: A write to the address register (select 0) stores the value with bits [1:0] forced to 0 and every bit at or above ADDR_W forced to 0.
- R2: The transfer length in words is block register bits [31:16] multiplied by bits [15:0]; the block register is written with select 1.
- R3: A control value of exactly 0x01000201 reads memory words at rising word addresses from the start address and presents each on `out_data` with `out_valid` until `out_ready`.
- R4: A control value of exactly 0x01000200 raises `in_ready`. Each word accepted with `in_valid` is written to memory at rising word addresses from the start address.
- R5: A control write (select 2) whose bit 24 is 0 stores the value and starts nothing: `busy` stays 0, and no data moves and no interrupt is raised.
- R6: A control write with bit 24 set and any other value moves no data, leaves the address unchanged, clears bit 24 and gives one interrupt pulse.
- R7: At the end of a transfer, the address register equals the start address plus four times the words moved, modulo 2^ADDR_W. The control register keeps every bit except bit 24, which is cleared.
- R8: `busy` equals control bit 24 and rises the cycle after a start write. `irq` is high for exactly one cycle per started transfer, and `busy` is 0 on the cycle after it.
- R9: While `busy` is 1, writes to all three registers are ignored.
- R10: A length of zero finishes with one interrupt pulse and moves no data.
- R11: A transfer that moves the word at the last word address of memory stops after that word. It moves fewer words than programmed, and the final address wraps to 0.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 block, 2 control |
| reg_wdata | input | 32 | Register write data |
| addr_reg | output | 32 | Current address register |
| blk_reg | output | 32 | Block register |
| ctrl_reg | output | 32 | Control register |
| busy | output | 1 | Control bit 24 |
| irq | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data, valid the cycle after a read request |
| out_valid | output | 1 | Word offered to the peripheral |
| out_data | output | WORD_W | Word to the peripheral |
| out_ready | input | 1 | Peripheral accepts the offered word |
| in_valid | input | 1 | Peripheral offers a word |
| in_data | input | WORD_W | Word from the peripheral |
| in_ready | output | 1 | Channel accepts the peripheral word |

## Verification
The bench aims at the top of memory. A start a few words below the last word address must stop early and wrap the address to 0. A design without that check would write or read past the top and report the wrong final address.

Zero-length blocks, unknown control codes and control writes without bit 24 must all leave the data and the peripheral untouched. A design that got these wrong would stream words, hang in the busy state or skip the interrupt.

Register writes made in the middle of a transfer must be ignored. A design that accepted them would corrupt the length or the final address.

Random stalls on the peripheral side check that each word is held until it is accepted. A design that advanced early would drop or repeat words in the received stream.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam int REG_W     = 32;
    localparam int START_BIT = 24;

    localparam logic [REG_W-1:0] CTL_TO_PERIPH   = 32'h0100_0201;
    localparam logic [REG_W-1:0] CTL_FROM_PERIPH = 32'h0100_0200;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_BLOCK = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_MEM_RD,
        ST_MEM_LAT,
        ST_PUSH,
        ST_PULL,
        ST_FINISH
    } dma_state_e;

    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_TO_PERIPH,
        DIR_FROM_PERIPH
    } dma_dir_e;

endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    input  logic [REG_W-1:0]  sw_wdata,
    input  logic              adv_addr,
    input  logic              finish,
    output logic              start,
    output logic [ADDR_W-1:0] addr_q,
    output logic [REG_W-1:0]  blk_q,
    output logic [REG_W-1:0]  ctl_q
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic wr_ok;

    // Software may only touch the registers while the channel is idle.
    assign wr_ok = sw_we && !ctl_q[START_BIT];
    assign start = wr_ok && (sw_sel == SEL_CTRL) && sw_wdata[START_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_ok && (sw_sel == SEL_ADDR)) begin
            addr_q <= {sw_wdata[ADDR_W-1:2], 2'b00};
        end else if (adv_addr) begin
            addr_q <= addr_q + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (wr_ok && (sw_sel == SEL_BLOCK)) begin
            blk_q <= sw_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ok && (sw_sel == SEL_CTRL)) begin
            ctl_q <= sw_wdata;
        end else if (finish) begin
            ctl_q[START_BIT] <= 1'b0;
        end
    end

endmodule

// File: rtl/blkdma_decode.sv
module blkdma_decode
    import blkdma_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic [REG_W-1:0] ctl,
    input  logic [REG_W-1:0] blk,
    output dma_dir_e         dir,
    output logic [LEN_W-1:0] len
);

    localparam int HALF_W = REG_W / 2;

    logic [LEN_W-1:0] count_hi;
    logic [LEN_W-1:0] count_lo;

    assign count_hi = LEN_W'(blk[REG_W-1:HALF_W]);
    assign count_lo = LEN_W'(blk[HALF_W-1:0]);
    assign len      = count_hi * count_lo;

    always_comb begin
        if (ctl == CTL_TO_PERIPH) begin
            dir = DIR_TO_PERIPH;
        end else if (ctl == CTL_FROM_PERIPH) begin
            dir = DIR_FROM_PERIPH;
        end else begin
            dir = DIR_NONE;
        end
    end

endmodule

// File: rtl/blkdma_fsm.sv
module blkdma_fsm
    import blkdma_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  dma_dir_e          dir,
    input  logic [LEN_W-1:0]  len,
    input  logic              at_top,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              in_ready,
    output logic              adv_addr,
    output logic              finish,
    output logic              irq
);

    dma_state_e        state_q;
    dma_state_e        state_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [WORD_W-1:0] hold_q;
    logic              last_beat;

    // The word in flight is the last one when the count is reached or
    // when it sits at the highest word address of memory.
    assign last_beat = ((cnt_q + LEN_W'(1)) == len) || at_top;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (dir == DIR_NONE || len == '0) begin
                    state_d = ST_FINISH;
                end else if (dir == DIR_TO_PERIPH) begin
                    state_d = ST_MEM_RD;
                end else begin
                    state_d = ST_PULL;
                end
            end
            ST_MEM_RD:  state_d = ST_MEM_LAT;
            ST_MEM_LAT: state_d = ST_PUSH;
            ST_PUSH: begin
                if (out_ready) state_d = last_beat ? ST_FINISH : ST_MEM_RD;
            end
            ST_PULL: begin
                if (in_valid) state_d = last_beat ? ST_FINISH : ST_PULL;
            end
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = in_data;
        out_valid = 1'b0;
        out_data  = hold_q;
        in_ready  = 1'b0;
        adv_addr  = 1'b0;
        finish    = 1'b0;
        irq       = 1'b0;
        unique case (state_q)
            ST_MEM_RD: begin
                mem_req = 1'b1;
            end
            ST_PUSH: begin
                out_valid = 1'b1;
                adv_addr  = out_ready;
            end
            ST_PULL: begin
                in_ready = 1'b1;
                mem_req  = in_valid;
                mem_we   = in_valid;
                adv_addr = in_valid;
            end
            ST_FINISH: begin
                finish = 1'b1;
                irq    = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_SETUP) begin
            cnt_q <= '0;
        end else if (adv_addr) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state_q == ST_MEM_LAT) begin
            hold_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/blkdma_channel.sv
module blkdma_channel
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       addr_reg,
    output logic [31:0]       blk_reg,
    output logic [31:0]       ctrl_reg,
    output logic              busy,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready
);

    localparam int LEN_W  = REG_W;
    localparam int WADR_W = ADDR_W - 2;

    logic              start;
    logic              adv_addr;
    logic              finish;
    logic              at_top;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  blk_q;
    logic [REG_W-1:0]  ctl_q;
    dma_dir_e          dir;
    logic [LEN_W-1:0]  len;

    blkdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (reg_we),
        .sw_sel   (reg_sel),
        .sw_wdata (reg_wdata),
        .adv_addr (adv_addr),
        .finish   (finish),
        .start    (start),
        .addr_q   (addr_q),
        .blk_q    (blk_q),
        .ctl_q    (ctl_q)
    );

    blkdma_decode #(.LEN_W(LEN_W)) u_decode (
        .ctl (ctl_q),
        .blk (blk_q),
        .dir (dir),
        .len (len)
    );

    assign mem_addr = addr_q[ADDR_W-1:2];
    assign at_top   = &addr_q[ADDR_W-1:2];

    blkdma_fsm #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir       (dir),
        .len       (len),
        .at_top    (at_top),
        .mem_rdata (mem_rdata),
        .out_ready (out_ready),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .out_valid (out_valid),
        .out_data  (out_data),
        .in_ready  (in_ready),
        .adv_addr  (adv_addr),
        .finish    (finish),
        .irq       (irq)
    );

    assign addr_reg = {{(32 - ADDR_W){1'b0}}, addr_q};
    assign blk_reg  = blk_q;
    assign ctrl_reg = ctl_q;
    assign busy     = ctl_q[START_BIT];

    // Unused upper part of the word address is absent by construction.
    logic unused_wadr;
    assign unused_wadr = ^mem_addr[WADR_W-1:0] & 1'b0;

endmodule

// File: rtl/blkdma_checker.sv
module blkdma_checker #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       addr_reg,
    input logic [31:0]       blk_reg,
    input logic              busy,
    input logic              irq,
    input logic              mem_req,
    input logic              mem_we,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              out_ready,
    input logic              in_valid,
    input logic              in_ready
);

    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        addr_reg[1:0] == 2'b00);

    a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, in_ready}));

    a_r4_write_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (in_valid && in_ready));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !out_valid && !in_ready));

    a_r5_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd2 && !busy && !reg_wdata[24]) |=> !busy);

    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r8_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !busy);

    a_r9_block_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_sel == 2'd1) |=> $stable(blk_reg));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind blkdma_channel blkdma_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .addr_reg  (addr_reg),
    .blk_reg   (blk_reg),
    .busy      (busy),
    .irq       (irq),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .in_valid  (in_valid),
    .in_ready  (in_ready)
);

// File: tb/blkdma_channel_bench.sv
module blkdma_channel_bench;

    localparam int ADDR_W = 12;
    localparam int WORDS  = 1 << (ADDR_W - 2);
    localparam logic [31:0] AMASK = ((32'd1 << ADDR_W) - 32'd1) & ~32'd3;
    localparam logic [31:0] C_M2P = 32'h0100_0201;
    localparam logic [31:0] C_P2M = 32'h0100_0200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [31:0]       reg_wdata = 32'd0;
    logic [31:0]       addr_reg, blk_reg, ctrl_reg;
    logic              busy, irq, mem_req, mem_we;
    logic [ADDR_W-3:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = 32'd0;
    logic              out_valid;
    logic [31:0]       out_data;
    logic              out_ready = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_data;
    logic              in_ready;

    int checks = 0;
    int errors = 0;
    int rdy_pct = 100;

    logic [31:0] mem    [0:WORDS-1];
    logic [31:0] shadow [0:WORDS-1];
    logic [31:0] rx     [0:4095];
    logic [31:0] rx_n  = 32'd0;
    logic [31:0] src_n = 32'd0;
    logic [31:0] irq_n = 32'd0;

    blkdma_channel #(.ADDR_W(ADDR_W), .WORD_W(32)) u_blkdma_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_reg(addr_reg), .blk_reg(blk_reg),
        .ctrl_reg(ctrl_reg), .busy(busy), .irq(irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] fill_word(input int i);
        return (i * 32'h9E37_79B1) ^ 32'hA5A5_0000;
    endfunction

    function automatic logic [31:0] gen_word(input logic [31:0] k);
        return (k * 32'h0101_0107) + 32'h5A00_0013;
    endfunction

    function automatic logic [31:0] exp_len(input logic [31:0] blk);
        return {16'd0, blk[31:16]} * {16'd0, blk[15:0]};
    endfunction

    function automatic logic [31:0] exp_moved(input logic [31:0] a, input logic [31:0] len);
        logic [31:0] room;
        room = WORDS - (a >> 2);
        return (len < room) ? len : room;
    endfunction

    assign in_data = gen_word(src_n);

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (out_valid && out_ready) begin
            rx[rx_n[11:0]] <= out_data;
            rx_n <= rx_n + 32'd1;
        end
        if (in_valid && in_ready) src_n <= src_n + 32'd1;
        if (irq) irq_n <= irq_n + 32'd1;
    end

    always @(negedge clk) begin
        out_ready = ($urandom_range(99) < rdy_pct);
        in_valid  = ($urandom_range(99) < rdy_pct);
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run_xfer(input logic [31:0] a_in, input logic [31:0] blk,
                            input logic [31:0] ctl, input int pct, input bit poke,
                            input string tag);
        logic [31:0] a, rx0, s0, i0, len, moved, exp_a, base;
        bit m2p, p2m;
        int guard;
        rdy_pct = pct;
        a = a_in & AMASK;
        wr(2'd0, a_in);
        chk("R1", {tag, " address mask"}, addr_reg, a);
        wr(2'd1, blk);
        wr(2'd2, ctl);
        rx0 = rx_n; s0 = src_n; i0 = irq_n;
        m2p = (ctl == C_M2P);
        p2m = (ctl == C_P2M);
        len = exp_len(blk);
        moved = (m2p || p2m) ? exp_moved(a, len) : 32'd0;
        base = a >> 2;
        if (!ctl[24]) begin
            chk("R5", {tag, " busy after plain write"}, {31'd0, busy}, 32'd0);
            chk("R5", {tag, " control stored"}, ctrl_reg, ctl);
            repeat (6) @(negedge clk);
            chk("R5", {tag, " no irq"}, irq_n - i0, 32'd0);
            chk("R5", {tag, " no words out"}, rx_n - rx0, 32'd0);
            chk("R5", {tag, " no words in"}, src_n - s0, 32'd0);
            return;
        end
        chk("R8", {tag, " busy after start"}, {31'd0, busy}, 32'd1);
        if (poke) begin
            wr(2'd1, ~blk);
            wr(2'd0, a_in ^ 32'h0000_0100);
            wr(2'd2, 32'h0100_0000);
        end
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk("R8", {tag, " completion"}, {31'd0, busy}, 32'd0);
        chk("R8", {tag, " irq pulse count"}, irq_n - i0, 32'd1);
        chk("R7", {tag, " control after end"}, ctrl_reg, ctl & ~32'h0100_0000);
        exp_a = (m2p || p2m) ? ((a + 32'd4 * moved) & ((32'd1 << ADDR_W) - 32'd1)) : a;
        chk("R7", {tag, " final address"}, addr_reg, exp_a);
        chk("R9", {tag, " block register kept"}, blk_reg, blk);
        if (m2p) begin
            chk("R2", {tag, " words sent"}, rx_n - rx0, moved);
            chk("R2", {tag, " words taken"}, src_n - s0, 32'd0);
            for (int k = 0; k < int'(moved); k++)
                chk("R3", {tag, " sent word"}, rx[(rx0 + 32'(k)) & 32'hFFF], shadow[base + 32'(k)]);
        end else if (p2m) begin
            chk("R2", {tag, " words taken"}, src_n - s0, moved);
            chk("R2", {tag, " words sent"}, rx_n - rx0, 32'd0);
            for (int k = 0; k < int'(moved); k++) begin
                chk("R4", {tag, " stored word"}, mem[base + 32'(k)], gen_word(s0 + 32'(k)));
                shadow[base + 32'(k)] = gen_word(s0 + 32'(k));
            end
            chk("R4", {tag, " word past end untouched"},
                mem[(base + moved) % WORDS], shadow[(base + moved) % WORDS]);
        end else begin
            chk("R6", {tag, " no words out"}, rx_n - rx0, 32'd0);
            chk("R6", {tag, " no words in"}, src_n - s0, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = fill_word(i);
            shadow[i] = fill_word(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset busy", {31'd0, busy}, 32'd0);
        chk("R8", "reset irq", {31'd0, irq}, 32'd0);
        chk("R1", "reset address", addr_reg, 32'd0);
        chk("R7", "reset control", ctrl_reg, 32'd0);

        run_xfer(32'h0000_0100, 32'h0002_0003, C_M2P, 100, 1'b0, "R3 m2p basic");
        run_xfer(32'h0000_0203, 32'h0003_0004, C_P2M, 50, 1'b0, "R4 p2m basic");
        run_xfer(32'h0000_0300, 32'h0001_0004, 32'h0000_0201, 100, 1'b0, "R5 no start bit");
        run_xfer(32'h0000_0300, 32'h0001_0004, 32'h0100_0001, 100, 1'b0, "R6 unknown code");
        run_xfer(32'h0000_0300, 32'h0000_0005, C_M2P, 100, 1'b0, "R10 zero high half");
        run_xfer(32'h0000_0300, 32'h0007_0000, C_P2M, 100, 1'b0, "R10 zero low half");
        run_xfer(32'hABCD_1FF3, 32'h0001_000A, C_P2M, 100, 1'b0, "R11 p2m at top");
        run_xfer(32'h0000_0FF8, 32'h0001_0005, C_M2P, 100, 1'b0, "R11 m2p at top");
        run_xfer(32'h0000_0400, 32'h0004_0005, C_M2P, 30, 1'b1, "R9 writes while busy");
        run_xfer(32'h0000_0600, 32'h0005_0004, C_P2M, 30, 1'b1, "R9 writes while busy p2m");
        run_xfer(32'h0000_0500, 32'h0003_0003, C_M2P, 15, 1'b0, "R12 slow sink");

        for (int it = 0; it < 40; it++) begin
            logic [31:0] a, b, c;
            int r;
            r = $urandom_range(9);
            a = ($urandom_range(WORDS - 1) << 2) | $urandom_range(3);
            b = {16'($urandom_range(3)), 16'($urandom_range(9))};
            if (r == 0)      c = 32'h0100_0000 | $urandom_range(255);
            else if (r == 1) c = 32'h0000_0201;
            else if (r < 6)  c = C_M2P;
            else             c = C_P2M;
            run_xfer(a, b, c, 20 + $urandom_range(80), 1'b0, "R2 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule